// File: doc/BRIEF.md
# Interrupt Acknowledge Autovector Responder

This block sits beside a processor's interrupt acknowledge path. For each acknowledge, it decides whether to answer with an internal autovector indication for the acknowledged external interrupt level. It also reports whether this source wins arbitration against a neighbouring peripheral interrupt source that always competes with a fixed arbitration identifier of 8.

Software programs the block through a small register bus. One register holds a per-level autovector enable mask. A second holds a 4-bit arbitration identifier. A third holds a sticky flag that records a misconfigured identifier.

An acknowledge is presented as a strobe together with a 3-bit level. Both results appear as registered outputs on the following clock. Reset is asynchronous and active low. It is released to the internal logic through a two-stage synchronizer.

Top module: `irq_autovector_resp`

## Requirements
- R1: After reset, all three registers read as zero, and `av_pulse` and `arb_won` are low.
- R2: Address 0 holds the enable mask. Bit n, for n in 1..7, enables autovectoring for level n. Bit 0 always reads 0, and writes to bit 0 have no effect.
- R3: Address 1 holds the arbitration identifier in bits 3:0. Bits 7:4 read 0.
- R4: `av_pulse` is high for exactly the one cycle after a clock edge that samples `iack_stb` high, provided all of the following hold: the level is nonzero, its mask bit is set, and the identifier is nonzero.
- R5: An acknowledge at level 0 never produces `av_pulse` or `arb_won`.
- R6: While the identifier is zero, no acknowledge produces `av_pulse`, even when every mask bit is set.
- R7: `arb_won` is high for the one cycle after a sampled acknowledge at a nonzero level if and only if the identifier, taken as unsigned, is greater than 8. Under this rule 0xF wins, while 0x1 and 0x8 lose.
- R8: Writing an identifier of 8 sets a sticky error flag at bit 0 of address 2. Only a write to address 2 with bit 0 set clears it. A write there with bit 0 clear leaves it unchanged.
- R9: A register write takes effect at the clock edge that samples the write strobe. An acknowledge sampled at that same edge is decided with the previous register contents.
- R10: Unused address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| iack_stb | input | 1 | Interrupt acknowledge strobe |
| iack_lvl | input | 3 | Acknowledged interrupt level |
| av_pulse | output | 1 | Autovector indication, one cycle after the acknowledge |
| arb_won | output | 1 | Arbitration won against the peer with identifier 8 |

## Verification
The hardest case to reach is the collision between a register write and an acknowledge on the same clock edge. In that case the decision must use the register contents from before the write. The bench creates this case by raising the write strobe and the acknowledge strobe in the same half cycle. It then checks that the first acknowledge sees the old mask and that a second acknowledge sees the new one. Identifier values just above and below the peer value of 8, and exactly 8, are each programmed before acknowledges to cover the unsigned boundary.

// File: rtl/iav_pkg.sv
package iav_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int LEVELS  = 7;
  localparam int ID_W    = 4;
  localparam int PEER_ID = 8;
  localparam int LVL_W   = $clog2(LEVELS + 1);

  typedef enum logic [ADDR_W-1:0] {
    ADR_MASK = 2'd0,
    ADR_ARB  = 2'd1,
    ADR_STAT = 2'd2,
    ADR_NONE = 2'd3
  } reg_adr_e;
endpackage

// File: rtl/iav_regfile.sv
module iav_regfile
  import iav_pkg::*;
#(
  parameter int P_DATA_W  = DATA_W,
  parameter int P_LEVELS  = LEVELS,
  parameter int P_ID_W    = ID_W,
  parameter int P_PEER_ID = PEER_ID
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [P_DATA_W-1:0] reg_wdata,
  output logic [P_DATA_W-1:0] reg_rdata,
  output logic [P_LEVELS:1]   mask_o,
  output logic [P_ID_W-1:0]   id_o,
  output logic                err_o
);
  localparam logic [P_ID_W-1:0] PEER = P_ID_W'(P_PEER_ID);

  logic [P_LEVELS:1] mask_q, mask_d;
  logic [P_ID_W-1:0] id_q, id_d;
  logic              err_q, err_d;
  logic              mask_en, id_en, err_en;
  logic              wr_mask, wr_arb, wr_stat;
  reg_adr_e          adr;
  logic              unused_wdata;

  assign adr     = reg_adr_e'(reg_addr);
  assign wr_mask = reg_wr && (adr == ADR_MASK);
  assign wr_arb  = reg_wr && (adr == ADR_ARB);
  assign wr_stat = reg_wr && (adr == ADR_STAT);
  assign unused_wdata = ^reg_wdata;

  // next-state logic
  always_comb begin
    mask_en = wr_mask;
    mask_d  = reg_wdata[P_LEVELS:1];
    id_en   = wr_arb;
    id_d    = reg_wdata[P_ID_W-1:0];
    err_en  = 1'b0;
    err_d   = err_q;
    if (wr_arb && (reg_wdata[P_ID_W-1:0] == PEER)) begin
      err_en = 1'b1;
      err_d  = 1'b1;
    end else if (wr_stat && reg_wdata[0]) begin
      err_en = 1'b1;
      err_d  = 1'b0;
    end
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  // read multiplexer
  always_comb begin
    reg_rdata = '0;
    case (adr)
      ADR_MASK: reg_rdata[P_LEVELS:1]  = mask_q;
      ADR_ARB:  reg_rdata[P_ID_W-1:0]  = id_q;
      ADR_STAT: reg_rdata[0]           = err_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign id_o   = id_q;
  assign err_o  = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_stat && reg_wdata[0])) |=> err_q); // R8
  AST_ID_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arb |=> (id_q == $past(reg_wdata[P_ID_W-1:0]))); // R9
  AST_ERR_ON_PEER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_arb && (reg_wdata[P_ID_W-1:0] == PEER)) |=> err_q); // R8
endmodule

// File: rtl/iav_decide.sv
module iav_decide
  import iav_pkg::*;
#(
  parameter int P_LEVELS = LEVELS,
  parameter int P_ID_W   = ID_W,
  parameter int P_LVL_W  = $clog2(P_LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_stb,
  input  logic [P_LVL_W-1:0] ack_lvl,
  input  logic [P_LEVELS:1]  mask,
  input  logic [P_ID_W-1:0]  id,
  output logic               av_o
);
  logic [P_LEVELS:0] mask_full;
  logic              lvl_ok;
  logic              av_d, av_q;

  assign mask_full = {mask, 1'b0};

  always_comb begin
    lvl_ok = (ack_lvl != '0) && (int'(ack_lvl) <= P_LEVELS);
    av_d   = ack_stb && lvl_ok && mask_full[ack_lvl] && (id != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      av_q <= 1'b0;
    end else begin
      av_q <= av_d;
    end
  end

  assign av_o = av_q;

  AST_ID0_NO_AV: assert property (@(posedge clk) disable iff (!rst_n)
    av_q |-> ($past(id) != '0)); // R6
  AST_AV_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    av_q |-> $past(mask_full[ack_lvl])); // R4
endmodule

// File: rtl/iav_arbiter.sv
module iav_arbiter
  import iav_pkg::*;
#(
  parameter int P_ID_W    = ID_W,
  parameter int P_PEER_ID = PEER_ID,
  parameter int P_LVL_W   = LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_stb,
  input  logic [P_LVL_W-1:0] ack_lvl,
  input  logic [P_ID_W-1:0]  id,
  output logic               won_o
);
  localparam logic [P_ID_W-1:0] PEER = P_ID_W'(P_PEER_ID);

  logic won_d, won_q;

  always_comb begin
    won_d = ack_stb && (ack_lvl != '0) && (id > PEER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      won_q <= 1'b0;
    end else begin
      won_q <= won_d;
    end
  end

  assign won_o = won_q;

  AST_WON_ABOVE_PEER: assert property (@(posedge clk) disable iff (!rst_n)
    won_q |-> ($past(id) > PEER)); // R7
endmodule

// File: rtl/irq_autovector_resp.sv
module irq_autovector_resp
  import iav_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              iack_stb,
  input  logic [LVL_W-1:0]  iack_lvl,
  output logic              av_pulse,
  output logic              arb_won
);
  logic [1:0]      rst_sync;
  logic            rst_core_n;
  logic [LEVELS:1] mask;
  logic [ID_W-1:0] id;
  logic            cfg_err;
  logic            unused_err;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  iav_regfile #(
    .P_DATA_W(DATA_W), .P_LEVELS(LEVELS), .P_ID_W(ID_W), .P_PEER_ID(PEER_ID)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mask_o(mask), .id_o(id), .err_o(cfg_err)
  );

  iav_decide #(
    .P_LEVELS(LEVELS), .P_ID_W(ID_W), .P_LVL_W(LVL_W)
  ) u_decide (
    .clk(clk), .rst_n(rst_core_n), .ack_stb(iack_stb), .ack_lvl(iack_lvl),
    .mask(mask), .id(id), .av_o(av_pulse)
  );

  iav_arbiter #(
    .P_ID_W(ID_W), .P_PEER_ID(PEER_ID), .P_LVL_W(LVL_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_core_n), .ack_stb(iack_stb), .ack_lvl(iack_lvl),
    .id(id), .won_o(arb_won)
  );

  assign unused_err = cfg_err;

  AST_AV_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_core_n)
    av_pulse |-> $past(iack_stb)); // R4
  AST_LVL0_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    (av_pulse || arb_won) |-> ($past(iack_lvl) != '0)); // R5
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_addr == 2'd0) |-> (reg_rdata[0] == 1'b0)); // R2
endmodule

// File: tb/irq_autovector_resp_test.sv
module irq_autovector_resp_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       iack_stb = 1'b0;
  logic [2:0] iack_lvl = '0;
  logic       av_pulse, arb_won;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_autovector_resp uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iack_stb(iack_stb),
    .iack_lvl(iack_lvl), .av_pulse(av_pulse), .arb_won(arb_won)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  // acknowledge one cycle, check both outputs the cycle after, then check they drop
  task automatic ack(input string req, input logic [2:0] l, input bit exp_av, input bit exp_won);
    @(negedge clk);
    iack_stb = 1'b1; iack_lvl = l;
    @(negedge clk);
    iack_stb = 1'b0; iack_lvl = '0;
    check({req, " av"}, {7'b0, av_pulse}, {7'b0, exp_av});
    check({req, " won"}, {7'b0, arb_won}, {7'b0, exp_won});
    @(negedge clk);
    check({req, " av drop"}, {7'b0, av_pulse}, 8'h00);
  endtask

  task automatic t_reset;
    rd_check("R1 mask", 2'd0, 8'h00);
    rd_check("R1 id", 2'd1, 8'h00);
    rd_check("R1 err", 2'd2, 8'h00);
    check("R1 av", {7'b0, av_pulse}, 8'h00);
    check("R1 won", {7'b0, arb_won}, 8'h00);
  endtask

  task automatic t_regs;
    wr(2'd0, 8'hFF);
    rd_check("R2 bit0 ignored", 2'd0, 8'hFE);
    wr(2'd0, 8'h55);
    rd_check("R2 mask pattern", 2'd0, 8'h54);
    wr(2'd1, 8'hA3);
    rd_check("R3 id upper zero", 2'd1, 8'h03);
    rd_check("R10 addr3", 2'd3, 8'h00);
  endtask

  task automatic t_id_zero;
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h00);
    for (int l = 1; l < 8; l++) ack("R6 id zero", 3'(l), 1'b0, 1'b0);
  endtask

  task automatic t_mask_levels;
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h28); // levels 3 and 5
    for (int l = 1; l < 8; l++) ack("R4 mask level", 3'(l), (l == 3 || l == 5), 1'b0);
    wr(2'd0, 8'hFE);
    ack("R5 level zero", 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_arb;
    wr(2'd1, 8'h0F);
    ack("R7 id F wins", 3'd2, 1'b1, 1'b1);
    wr(2'd1, 8'h09);
    ack("R7 id 9 wins", 3'd7, 1'b1, 1'b1);
    wr(2'd1, 8'h07);
    ack("R7 id 7 loses", 3'd7, 1'b1, 1'b0);
    wr(2'd1, 8'h08);
    ack("R7 id 8 loses", 3'd4, 1'b1, 1'b0);
    wr(2'd1, 8'h0F);
    ack("R5 level zero no win", 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_err;
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h03);
    rd_check("R8 err clear", 2'd2, 8'h00);
    wr(2'd1, 8'h08);
    rd_check("R8 err set", 2'd2, 8'h01);
    wr(2'd1, 8'h0F);
    rd_check("R8 err sticky after id change", 2'd2, 8'h01);
    wr(2'd2, 8'h00);
    rd_check("R8 write zero no clear", 2'd2, 8'h01);
    wr(2'd2, 8'h01);
    rd_check("R8 write one clears", 2'd2, 8'h00);
  endtask

  task automatic t_collide;
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h00);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'hFE; reg_wr = 1'b1;
    iack_stb = 1'b1; iack_lvl = 3'd6;
    @(negedge clk);
    reg_wr = 1'b0; iack_stb = 1'b0; iack_lvl = '0;
    check("R9 same-edge uses old mask", {7'b0, av_pulse}, 8'h00);
    ack("R9 new mask applies", 3'd6, 1'b1, 1'b1);
    // held strobe: one pulse per sampled acknowledge
    @(negedge clk);
    iack_stb = 1'b1; iack_lvl = 3'd1;
    @(negedge clk);
    check("R4 held ack cycle1", {7'b0, av_pulse}, 8'h01);
    @(negedge clk);
    iack_stb = 1'b0;
    check("R4 held ack cycle2", {7'b0, av_pulse}, 8'h01);
    @(negedge clk);
    check("R4 released", {7'b0, av_pulse}, 8'h00);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_id_zero();
    t_mask_levels();
    t_arb();
    t_err();
    t_collide();
    done = 1'b1;
    finish_run();
  end
endmodule